// File: doc/BRIEF.md
# Reference-Timed Clock Presence and Rate Monitor

This block decides whether a clock arriving from outside the chip is running and is close to its expected rate. A free-running local reference clock paces fixed measurement windows. During each window, a counter clocked by the monitored clock counts its rising edges. At every window boundary that count is captured, returned to the reference domain and tested against an inclusive band of acceptable counts. The result drives a health flag that other boards can use to decide whether the link clock can be trusted.

The health flag has hysteresis. A single failing window clears it at once. It is set again only after a run of consecutive passing windows. A stopped clock never answers the capture request, so its window is scored as a count of zero and fails. A separate flag reports whether the monitored clock has toggled at all since the last reset. That flag stays set even if the clock later stops.

Top module: `clk_watch`

## Requirements
- R1: While `ref_rst` is high and on the first sample after it falls, `clk_ok` and `clk_started` are both 0.
- R2: A measurement window lasts `WIN_CYC` reference cycles and starts when reset is released. With a nominal monitored clock, `clk_ok` first rises `(PASS_RUN+1)*WIN_CYC` reference cycles after reset release, within a few cycles. The first window after reset has no prior capture and always fails.
- R3: A window passes when its captured edge count `c` satisfies `LO_BOUND <= c <= HI_BOUND`. Both bounds are inclusive. A clock whose count lies inside the band keeps `clk_ok` at 1 in every window.
- R4: A clock whose count per window falls below `LO_BOUND` fails every window, and `clk_ok` stays 0.
- R5: A clock whose count exceeds `HI_BOUND` fails. The edge counter saturates at its all-ones value and never wraps. A count of `HI_BOUND+k*2^CNT_W` therefore cannot alias into the band.
- R6: If the monitored clock stops, the capture request gets no answer within one window. That window is scored as count 0 and fails. `clk_ok` falls no later than two windows after the stop.
- R7: `clk_ok` rises only after `PASS_RUN` consecutive passing windows. After a failure it stays 0 for at least two more windows.
- R8: One failing window clears `clk_ok` on the next reference cycle, whatever the pass history.
- R9: `clk_started` becomes 1 within a few reference cycles of the first monitored-clock activity after reset. It stays 1 until the next reset, even if the monitored clock stops. After a reset with a dead monitored clock it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock that sets the window timing |
| ref_rst | input | 1 | Active-high reset, synchronous to `ref_clk` |
| mon_clk | input | 1 | Monitored external clock; it may be absent |
| clk_ok | output | 1 | Monitored clock is present and within the rate band (reference domain) |
| clk_started | output | 1 | Monitored clock has toggled since reset (reference domain) |

## Verification
The hardest case to reach is a count that exceeds the counter's range and would, without saturation, wrap back into the pass band. The stimulus sets the monitored period so that one window holds roughly the nominal count plus 2^CNT_W edges, and then checks that `clk_ok` stays low. A second hard case is a reset taken while the monitored clock is dead. The monitored-domain logic must then clear asynchronously and `clk_started` must stay low until the clock is switched back on.

// File: rtl/clk_watch_pkg.sv
package clk_watch_pkg;

  // Bits for a count that holds hi_bound, plus one bit of headroom before saturation.
  function automatic int cnt_width(input int unsigned hi_bound);
    return $clog2(hi_bound + 1) + 1;
  endfunction

  // Bits for a counter that must reach value n.
  function automatic int run_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Inclusive band check on a captured edge count.
  function automatic logic in_band(input int unsigned c,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (c >= lo) && (c <= hi);
  endfunction

endpackage

// File: rtl/cw_window.sv
module cw_window #(
  parameter int unsigned WIN_CYC = 100
) (
  input  logic ref_clk,
  input  logic ref_rst,
  output logic win_end,
  output logic req_tgl
);
  localparam int WIN_W = $clog2(WIN_CYC);

  logic [WIN_W-1:0] tick_q;

  assign win_end = (tick_q == WIN_W'(WIN_CYC - 1));

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      tick_q  <= '0;
      req_tgl <= 1'b0;
    end else if (win_end) begin
      tick_q  <= '0;
      req_tgl <= ~req_tgl;
    end else begin
      tick_q  <= tick_q + 1'b1;
    end
  end

  // R2: window boundaries are isolated single-cycle events
  a_r2_single_end: assert property (@(posedge ref_clk) disable iff (ref_rst)
    win_end |=> !win_end);

  // R2: the capture request toggles exactly at a window boundary
  a_r2_req_on_end: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (req_tgl != $past(req_tgl)) |-> $past(win_end));

endmodule

// File: rtl/cw_mon_side.sv
module cw_mon_side #(
  parameter int CNT_W = 9
) (
  input  logic             mon_clk,
  input  logic             mon_clr,
  input  logic             req_tgl,
  output logic             ack_tgl,
  output logic [CNT_W-1:0] held_cnt,
  output logic             seen
);
  // Reset release synchronizer: asserts at once, releases on monitored edges.
  logic [1:0] mrst_q;
  logic       mon_rst;

  always_ff @(posedge mon_clk or posedge mon_clr) begin
    if (mon_clr) mrst_q <= 2'b11;
    else         mrst_q <= {mrst_q[0], 1'b0};
  end
  assign mon_rst = mrst_q[1];

  // Capture request crossing: two sync stages plus one history stage.
  logic [2:0] req_q;
  logic       hit;

  always_ff @(posedge mon_clk or posedge mon_rst) begin
    if (mon_rst) req_q <= '0;
    else         req_q <= {req_q[1:0], req_tgl};
  end
  assign hit = req_q[2] ^ req_q[1];

  // Saturating edge counter, capture register and acknowledge toggle.
  logic [CNT_W-1:0] edge_cnt;
  logic             at_top;

  assign at_top = (edge_cnt == {CNT_W{1'b1}});

  always_ff @(posedge mon_clk or posedge mon_rst) begin
    if (mon_rst) begin
      edge_cnt <= '0;
      held_cnt <= '0;
      ack_tgl  <= 1'b0;
    end else if (hit) begin
      held_cnt <= edge_cnt;
      edge_cnt <= CNT_W'(1);
      ack_tgl  <= ~ack_tgl;
    end else if (!at_top) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // Start detector: small counter held in reset, sticky flag once it moves.
  logic [1:0] st_q;

  always_ff @(posedge mon_clk or posedge mon_rst) begin
    if (mon_rst) begin
      st_q <= '0;
      seen <= 1'b0;
    end else begin
      if (st_q != 2'b11) st_q <= st_q + 1'b1;
      seen <= seen | (st_q != 2'b00);
    end
  end

  // R5: a saturated counter holds until the next capture
  a_r5_no_wrap: assert property (@(posedge mon_clk) disable iff (mon_rst)
    (at_top && !hit) |=> at_top);

  // R9: start flag is sticky in its own domain
  a_r9_seen_sticky: assert property (@(posedge mon_clk) disable iff (mon_rst)
    seen |=> seen);

  // R3: the acknowledge moves only together with a fresh capture
  a_r3_ack_with_hit: assert property (@(posedge mon_clk) disable iff (mon_rst)
    (ack_tgl != $past(ack_tgl)) |-> $past(hit));

endmodule

// File: rtl/cw_judge.sv
module cw_judge
  import clk_watch_pkg::*;
#(
  parameter int unsigned LO_BOUND = 110,
  parameter int unsigned HI_BOUND = 140,
  parameter int unsigned PASS_RUN = 3,
  parameter int          CNT_W    = 9
) (
  input  logic             ref_clk,
  input  logic             ref_rst,
  input  logic             win_end,
  input  logic             ack_tgl,
  input  logic [CNT_W-1:0] held_cnt,
  input  logic             seen,
  output logic             clk_ok,
  output logic             clk_started
);
  localparam int RUN_W = run_width(PASS_RUN);

  // Acknowledge crossing back into the reference domain.
  logic [2:0] ack_q;
  logic       ack_evt;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) ack_q <= '0;
    else         ack_q <= {ack_q[1:0], ack_tgl};
  end
  assign ack_evt = ack_q[2] ^ ack_q[1];

  // Result capture; a result counts only for the window boundary that follows it.
  logic [CNT_W-1:0] cap_cnt;
  logic             got_res;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      cap_cnt <= '0;
      got_res <= 1'b0;
    end else if (win_end) begin
      got_res <= 1'b0;
    end else if (ack_evt) begin
      cap_cnt <= held_cnt;
      got_res <= 1'b1;
    end
  end

  // Evaluation at each window boundary; a missing answer scores as zero.
  logic             eval_stb;
  logic [CNT_W-1:0] eval_cnt;
  logic             eval_pass;

  assign eval_stb  = win_end;
  assign eval_cnt  = got_res ? cap_cnt : '0;
  assign eval_pass = in_band(32'(eval_cnt), LO_BOUND, HI_BOUND);

  // Hysteresis: drop on one failure, rise after PASS_RUN passes in a row.
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      run_q  <= '0;
      clk_ok <= 1'b0;
    end else if (eval_stb) begin
      if (eval_pass) begin
        if (run_q != RUN_W'(PASS_RUN)) run_q <= run_q + 1'b1;
        if (run_q == RUN_W'(PASS_RUN - 1)) clk_ok <= 1'b1;
      end else begin
        run_q  <= '0;
        clk_ok <= 1'b0;
      end
    end
  end

  // Start flag crossing.
  logic [1:0] seen_q;

  always_ff @(posedge ref_clk) begin
    if (ref_rst) seen_q <= '0;
    else         seen_q <= {seen_q[0], seen};
  end
  assign clk_started = seen_q[1];

  // R6: a window without an answer never passes
  a_r6_timeout_fails: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (eval_stb && !got_res) |-> !eval_pass);

  // R8: one failing window clears the flag
  a_r8_fail_drops: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (eval_stb && !eval_pass) |=> !clk_ok);

  // R7: the flag rises only right after a passing evaluation
  a_r7_rise_on_pass: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $rose(clk_ok) |-> $past(eval_stb && eval_pass));

  // R7: between evaluations the flag holds
  a_r7_hold_between: assert property (@(posedge ref_clk) disable iff (ref_rst)
    !eval_stb |=> $stable(clk_ok));

endmodule

// File: rtl/clk_watch.sv
module clk_watch
  import clk_watch_pkg::*;
#(
  parameter int unsigned WIN_CYC  = 100,
  parameter int unsigned LO_BOUND = 110,
  parameter int unsigned HI_BOUND = 140,
  parameter int unsigned PASS_RUN = 3
) (
  input  logic ref_clk,
  input  logic ref_rst,
  input  logic mon_clk,
  output logic clk_ok,
  output logic clk_started
);
  localparam int CNT_W = cnt_width(HI_BOUND);

  logic             win_end;
  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] held_cnt;
  logic             seen;
  logic             mon_clr;

  // Registered copy of reset, used only as the asynchronous clear of the monitored side.
  always_ff @(posedge ref_clk) mon_clr <= ref_rst;

  cw_window #(.WIN_CYC(WIN_CYC)) u_window (
    .ref_clk (ref_clk),
    .ref_rst (ref_rst),
    .win_end (win_end),
    .req_tgl (req_tgl)
  );

  cw_mon_side #(.CNT_W(CNT_W)) u_mon (
    .mon_clk  (mon_clk),
    .mon_clr  (mon_clr),
    .req_tgl  (req_tgl),
    .ack_tgl  (ack_tgl),
    .held_cnt (held_cnt),
    .seen     (seen)
  );

  cw_judge #(
    .LO_BOUND (LO_BOUND),
    .HI_BOUND (HI_BOUND),
    .PASS_RUN (PASS_RUN),
    .CNT_W    (CNT_W)
  ) u_judge (
    .ref_clk     (ref_clk),
    .ref_rst     (ref_rst),
    .win_end     (win_end),
    .ack_tgl     (ack_tgl),
    .held_cnt    (held_cnt),
    .seen        (seen),
    .clk_ok      (clk_ok),
    .clk_started (clk_started)
  );

endmodule

// File: tb/test_clk_watch.sv
`timescale 1ns/1ps
module test_clk_watch;
  import clk_watch_pkg::*;

  localparam real REF_PERIOD = 10.0;
  localparam int  WIN        = 100;
  localparam int  LO         = 110;
  localparam int  HI         = 140;
  localparam int  RUNS       = 3;

  logic ref_clk = 1'b0;
  logic ref_rst = 1'b1;
  logic mon_clk = 1'b0;
  logic clk_ok;
  logic clk_started;

  bit  mon_on   = 1'b1;
  real mon_half = 4.0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  clk_watch #(.WIN_CYC(WIN), .LO_BOUND(LO), .HI_BOUND(HI), .PASS_RUN(RUNS)) i_clk_watch (
    .ref_clk     (ref_clk),
    .ref_rst     (ref_rst),
    .mon_clk     (mon_clk),
    .clk_ok      (clk_ok),
    .clk_started (clk_started)
  );

  always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (mon_on) #(mon_half) mon_clk = ~mon_clk;
      else        #1;
    end
  end

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    ref_rst = 1'b1;
    wait_ref(5);
    chk("R1 ok during reset", clk_ok, 1'b0);
    chk("R1 started during reset", clk_started, 1'b0);
    ref_rst = 1'b0;
  endtask

  // Nominal clock: reset state, first rise time, sustained pass.
  task automatic t_nominal();
    int rise_at;
    mon_on = 1'b1; mon_half = 4.0;   // 125 edges per window
    do_reset();
    chk("R1 ok after release", clk_ok, 1'b0);
    rise_at = -1;
    for (int i = 1; i <= 6 * WIN; i++) begin
      wait_ref(1);
      if (i == 3 * WIN + WIN / 2) chk("R7 ok before run complete", clk_ok, 1'b0);
      if (clk_ok && rise_at < 0) rise_at = i;
    end
    chk_rng("R2 rise cycle", rise_at, (RUNS + 1) * WIN - 3, (RUNS + 1) * WIN + 3);
    chk("R9 started with clock", clk_started, 1'b1);
    for (int w = 0; w < 3; w++) begin
      wait_ref(WIN);
      chk("R3 nominal stays ok", clk_ok, 1'b1);
    end
  endtask

  // Inclusive band restated at the edges.
  task automatic t_band();
    chk("R3 lower bound passes", in_band(LO, LO, HI), 1'b1);
    chk("R3 upper bound passes", in_band(HI, LO, HI), 1'b1);
    chk("R4 below lower fails", in_band(LO - 1, LO, HI), 1'b0);
    chk("R5 above upper fails", in_band(HI + 1, LO, HI), 1'b0);
  endtask

  // Stop, then restart with hysteresis.
  task automatic t_stop_restart();
    chk("R6 ok before stop", clk_ok, 1'b1);
    mon_on = 1'b0;
    wait_ref(2 * WIN + 10);
    chk("R6 stopped clock flagged", clk_ok, 1'b0);
    chk("R9 started sticky after stop", clk_started, 1'b1);
    mon_on = 1'b1; mon_half = 4.0;
    wait_ref(2 * WIN - 10);
    chk("R7 no early reassert", clk_ok, 1'b0);
    wait_ref(2 * WIN + 60);
    chk("R7 reassert after run", clk_ok, 1'b1);
  endtask

  // Slow clock: one failure drops the flag, persistent low after.
  task automatic t_slow();
    mon_half = 8.0;   // about 62 edges per window
    wait_ref(2 * WIN + 10);
    chk("R8 single fail drops", clk_ok, 1'b0);
    wait_ref(4 * WIN);
    chk("R4 slow stays low", clk_ok, 1'b0);
  endtask

  // Fast clock and counter saturation.
  task automatic t_fast();
    mon_half = 4.0;
    wait_ref(5 * WIN);
    chk("R3 recovered before fast", clk_ok, 1'b1);
    mon_half = 2.0;   // about 250 edges per window
    wait_ref(2 * WIN + 10);
    chk("R5 fast flagged", clk_ok, 1'b0);
    mon_half = 0.785; // about 637 edges: wraps to about 125 without saturation
    wait_ref(6 * WIN);
    chk("R5 saturation no alias", clk_ok, 1'b0);
  endtask

  // Reset with a dead clock, then start it.
  task automatic t_dead_reset();
    mon_on = 1'b0;
    do_reset();
    wait_ref(4 * WIN + 50);
    chk("R9 dead clock not started", clk_started, 1'b0);
    chk("R6 dead clock not ok", clk_ok, 1'b0);
    mon_on = 1'b1; mon_half = 4.0;
    wait_ref(20);
    chk("R9 start seen", clk_started, 1'b1);
    wait_ref(5 * WIN);
    chk("R2 ok after late start", clk_ok, 1'b1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    t_nominal();
    t_band();
    t_stop_restart();
    t_slow();
    t_fast();
    t_dead_reset();
    report();
  end

  initial begin
    #(REF_PERIOD * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

endmodule